// File: doc/BRIEF.md
# Overlapping Register Window File

This block holds a processor's integer registers as a ring of windows. The core always addresses 32 logical registers. A current window pointer decides which physical registers those numbers reach. Eight globals are shared by every window. Each window also owns a group of locals and a group of incoming-parameter registers. Its outgoing-parameter group is physically the incoming group of the window one step lower.

A procedure call (save) moves the pointer down one window. A return (restore) moves it up one window. No register contents are copied: arguments written to the caller's outs appear at once as the callee's ins. A per-window invalid mask marks the window that separates the newest frame from the oldest. A save or restore that would enter that window is refused, and the block raises a spill request or a fill request for one cycle. A trap handler outside the block moves the frame to or from memory and reloads the mask through the mask load port.

The block has two registered read ports and one write port, all addressed by logical register number.

Top module: `rwin_regfile`

## Requirements
- R1: Logical numbers 0..7 select globals shared by all windows, 8..15 the outs, 16..23 the locals and 24..31 the ins of the current window; a value written through one window is read back at the same logical number while the pointer is unchanged.
- R2: After a save, the new window's ins (24..31) read the values held in the old window's outs (8..15); after a restore, the outs again read what was written through those ins.
- R3: A save moves the pointer from p to (p-1) mod 8, and a restore moves it to (p+1) mod 8, with the new value visible on `cwp_o` after the clock edge. If save and restore are both high, the save is performed and the restore is ignored.
- R4: A save whose target window has its mask bit set leaves the pointer unchanged and sets `spill_req_o` high for exactly the one cycle after that edge.
- R5: A restore whose target window has its mask bit set leaves the pointer unchanged and sets `fill_req_o` high for exactly the one cycle after that edge; spill and fill requests are never high together.
- R6: Read data appears on the cycle after the address is presented. A read of the physical register being written in the same cycle returns the newly written data.
- R7: Logical register 0 always reads as zero, and writes to it are discarded.
- R8: Reset (synchronous, active high) sets the pointer to 0, sets the mask to 8'h02 (bit i marks window i invalid, so only window 1 is invalid), drops both requests, and clears the read data.
- R9: A mask load writes `wim_d_i` into the mask at the clock edge. A save or restore in the same cycle is judged against the old mask, and later ones against the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_i | input | 1 | Call: move to the next lower window |
| restore_i | input | 1 | Return: move to the next higher window |
| wim_we_i | input | 1 | Load the window invalid mask |
| wim_d_i | input | 8 | New window invalid mask, bit i = window i |
| rd_a_addr_i | input | 5 | Read port A logical register number |
| rd_a_data_o | output | 32 | Read port A data, one cycle later |
| rd_b_addr_i | input | 5 | Read port B logical register number |
| rd_b_data_o | output | 32 | Read port B data, one cycle later |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write logical register number |
| wr_data_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| wim_o | output | 8 | Current window invalid mask |
| spill_req_o | output | 1 | Window overflow, spill request pulse |
| fill_req_o | output | 1 | Window underflow, fill request pulse |

## Verification
The hardest state to reach from the ports is overflow after legitimate use, where the pointer has travelled down until its next step hits the one invalid window. To get there, the stimulus performs six saves in a row from the reset state, checking the pointer after each one, and then issues a seventh save that must be refused at window 2. The mask is then cleared through the load port so the pointer can run all the way round the ring, which exercises wrap in both directions. The overlap is shown by writing through the outs, saving, and reading through the ins.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  // Logical register groups, selected by the two upper logical address bits
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/rwf_addr_map.sv
module rwf_addr_map #(
  parameter int NWIN   = 8,
  parameter int GRP_SZ = 8,
  localparam int CWPW  = $clog2(NWIN),
  localparam int GSW   = $clog2(GRP_SZ),
  localparam int LAW   = GSW + 2,
  localparam int NPHYS = GRP_SZ + NWIN * 2 * GRP_SZ,
  localparam int PAW   = $clog2(NPHYS)
) (
  input  logic [CWPW-1:0] cwp,
  input  logic [LAW-1:0]  la,
  output logic [PAW-1:0]  pa
);
  import rwf_pkg::*;

  reg_grp_e        grp;
  logic [CWPW-1:0] win;
  logic [PAW-1:0]  idx;
  logic [PAW-1:0]  base;

  always_comb begin
    grp  = reg_grp_e'(la[LAW-1:GSW]);
    idx  = PAW'(la[GSW-1:0]);
    // outs live in the ins of the window one step lower
    win  = (grp == GRP_OUT) ? CWPW'(cwp - 1'b1) : cwp;
    base = PAW'(GRP_SZ) + PAW'(win) * PAW'(2 * GRP_SZ);
    unique case (grp)
      GRP_GLOBAL: pa = idx;
      GRP_LOCAL:  pa = base + PAW'(GRP_SZ) + idx;
      default:    pa = base + idx;
    endcase
  end

  always_comb begin
    if (la[LAW-1:GSW] == 2'd0)
      AST_GLOBAL_LOW: assert (pa < PAW'(GRP_SZ)); // R1
  end
endmodule

// File: rtl/rwf_win_ctl.sv
module rwf_win_ctl #(
  parameter int NWIN  = 8,
  localparam int CWPW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            wim_we_i,
  input  logic [NWIN-1:0] wim_d_i,
  output logic [CWPW-1:0] cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic            spill_o,
  output logic            fill_o
);
  logic [CWPW-1:0] cwp_q, cwp_dn, cwp_up;
  logic [NWIN-1:0] wim_q;
  logic            spill_q, fill_q;

  assign cwp_dn = CWPW'(cwp_q - 1'b1);
  assign cwp_up = CWPW'(cwp_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q   <= '0;
      wim_q   <= NWIN'(1) << 1;  // window above the pointer guards the ring
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
    end else begin
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
      if (wim_we_i) wim_q <= wim_d_i;
      if (save_i) begin
        if (wim_q[cwp_dn]) spill_q <= 1'b1;
        else               cwp_q   <= cwp_dn;
      end else if (restore_i) begin
        if (wim_q[cwp_up]) fill_q <= 1'b1;
        else               cwp_q  <= cwp_up;
      end
    end
  end

  assign cwp_o   = cwp_q;
  assign wim_o   = wim_q;
  assign spill_o = spill_q;
  assign fill_o  = fill_q;

  AST_SAVE_MOVE: assert property (@(posedge clk) disable iff (rst)
    (save_i && !wim_q[cwp_dn]) |=> (cwp_q == $past(cwp_dn))); // R3
  AST_RESTORE_MOVE: assert property (@(posedge clk) disable iff (rst)
    (!save_i && restore_i && !wim_q[cwp_up]) |=> (cwp_q == $past(cwp_up))); // R3
  AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk) disable iff (rst)
    spill_q |-> (cwp_q == $past(cwp_q))); // R4
  AST_NO_UNDERFLOW_MOVE: assert property (@(posedge clk) disable iff (rst)
    fill_q |-> (cwp_q == $past(cwp_q))); // R5
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(spill_q && fill_q)); // R5
endmodule

// File: rtl/rwf_regmem.sv
module rwf_regmem #(
  parameter int W     = 32,
  parameter int DEPTH = 136,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          wa,
  input  logic [W-1:0]           wd,
  input  logic [NRD-1:0][AW-1:0] ra,
  output logic [NRD-1:0][W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [W-1:0] rd_q;
    // physical entry 0 is global 0: hardwired zero
    always_ff @(posedge clk) begin
      if (rst)                         rd_q <= '0;
      else if (ra[g] == '0)            rd_q <= '0;
      else if (we && (wa == ra[g]))    rd_q <= wd;
      else                             rd_q <= mem[ra[g]];
    end
    assign rd[g] = rd_q;

    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
      (we && (wa == ra[g]) && (ra[g] != '0)) |=> (rd_q == $past(wd))); // R6
    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
      (ra[g] == '0) |=> (rd_q == '0)); // R7
  end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile #(
  parameter int NWIN   = 8,
  parameter int GRP_SZ = 8,
  parameter int W      = 32,
  localparam int CWPW  = $clog2(NWIN),
  localparam int LAW   = $clog2(GRP_SZ) + 2,
  localparam int NPHYS = GRP_SZ + NWIN * 2 * GRP_SZ,
  localparam int PAW   = $clog2(NPHYS),
  localparam int NPORT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            wim_we_i,
  input  logic [NWIN-1:0] wim_d_i,
  input  logic [LAW-1:0]  rd_a_addr_i,
  output logic [W-1:0]    rd_a_data_o,
  input  logic [LAW-1:0]  rd_b_addr_i,
  output logic [W-1:0]    rd_b_data_o,
  input  logic            wr_en_i,
  input  logic [LAW-1:0]  wr_addr_i,
  input  logic [W-1:0]    wr_data_i,
  output logic [CWPW-1:0] cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic            spill_req_o,
  output logic            fill_req_o
);
  logic [CWPW-1:0]            cwp;
  logic [NPORT-1:0][LAW-1:0]  la;
  logic [NPORT-1:0][PAW-1:0]  pa;
  logic [1:0][PAW-1:0]        ra;
  logic [1:0][W-1:0]          rdata;
  logic                       we;

  rwf_win_ctl #(.NWIN(NWIN)) ctl_i (
    .clk(clk), .rst(rst), .save_i(save_i), .restore_i(restore_i),
    .wim_we_i(wim_we_i), .wim_d_i(wim_d_i), .cwp_o(cwp), .wim_o(wim_o),
    .spill_o(spill_req_o), .fill_o(fill_req_o)
  );

  // port 0 = write, 1 = read A, 2 = read B; all map with the pointer of this cycle
  assign la[0] = wr_addr_i;
  assign la[1] = rd_a_addr_i;
  assign la[2] = rd_b_addr_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rwf_addr_map #(.NWIN(NWIN), .GRP_SZ(GRP_SZ)) map_i (
      .cwp(cwp), .la(la[p]), .pa(pa[p])
    );
  end

  assign we    = wr_en_i && (wr_addr_i != '0);
  assign ra[0] = pa[1];
  assign ra[1] = pa[2];

  rwf_regmem #(.W(W), .DEPTH(NPHYS), .NRD(2)) mem_i (
    .clk(clk), .rst(rst), .we(we), .wa(pa[0]), .wd(wr_data_i),
    .ra(ra), .rd(rdata)
  );

  assign rd_a_data_o = rdata[0];
  assign rd_b_data_o = rdata[1];
  assign cwp_o       = cwp;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wim_we_i |=> (wim_o == $past(wim_d_i))); // R9
endmodule

// File: tb/rwin_regfile_tb_top.sv
module rwin_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        save_i = 0, restore_i = 0, wim_we_i = 0, wr_en_i = 0;
  logic [7:0]  wim_d_i = '0;
  logic [4:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o;
  logic [2:0]  cwp_o;
  logic [7:0]  wim_o;
  logic        spill_req_o, fill_req_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  rwin_regfile dut_i (
    .clk(clk), .rst(rst), .save_i(save_i), .restore_i(restore_i),
    .wim_we_i(wim_we_i), .wim_d_i(wim_d_i),
    .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cwp_o(cwp_o), .wim_o(wim_o), .spill_req_o(spill_req_o), .fill_req_o(fill_req_o)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_SV = 2'd2, OP_RS = 2'd3;
  // {op, logical addr, data (write value or expected read), exp cwp, exp spill, exp fill}
  localparam int NV = 16;
  localparam logic [43:0] VEC [NV] = '{
    {OP_WR, 5'd8,  32'h0000_0011, 3'd0, 1'b0, 1'b0},
    {OP_WR, 5'd16, 32'h0000_0022, 3'd0, 1'b0, 1'b0},
    {OP_WR, 5'd1,  32'h0000_0033, 3'd0, 1'b0, 1'b0},
    {OP_RD, 5'd8,  32'h0000_0011, 3'd0, 1'b0, 1'b0},
    {OP_SV, 5'd0,  32'h0,         3'd7, 1'b0, 1'b0},
    {OP_RD, 5'd24, 32'h0000_0011, 3'd7, 1'b0, 1'b0},
    {OP_RD, 5'd1,  32'h0000_0033, 3'd7, 1'b0, 1'b0},
    {OP_WR, 5'd24, 32'h0000_0044, 3'd7, 1'b0, 1'b0},
    {OP_RS, 5'd0,  32'h0,         3'd0, 1'b0, 1'b0},
    {OP_RD, 5'd8,  32'h0000_0044, 3'd0, 1'b0, 1'b0},
    {OP_RD, 5'd16, 32'h0000_0022, 3'd0, 1'b0, 1'b0},
    {OP_RS, 5'd0,  32'h0,         3'd0, 1'b0, 1'b1},
    {OP_WR, 5'd0,  32'h0000_0055, 3'd0, 1'b0, 1'b0},
    {OP_RD, 5'd0,  32'h0,         3'd0, 1'b0, 1'b0},
    {OP_WR, 5'd31, 32'h0000_0066, 3'd0, 1'b0, 1'b0},
    {OP_RD, 5'd31, 32'h0000_0066, 3'd0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs are set at a falling edge; outputs are sampled at the next falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    save_i = 0; restore_i = 0; wim_we_i = 0; wr_en_i = 0;
  endtask

  task automatic do_save(input logic [2:0] ecwp, input logic espill, input string tag);
    save_i = 1;
    tick();
    check({tag, " cwp"}, 32'(cwp_o), 32'(ecwp));
    check({tag, " spill"}, 32'(spill_req_o), 32'(espill));
  endtask

  task automatic do_restore(input logic [2:0] ecwp, input logic efill, input string tag);
    restore_i = 1;
    tick();
    check({tag, " cwp"}, 32'(cwp_o), 32'(ecwp));
    check({tag, " fill"}, 32'(fill_req_o), 32'(efill));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 reset state
    check("R8 cwp", 32'(cwp_o), 32'd0);
    check("R8 mask", 32'(wim_o), 32'h02);
    check("R8 spill", 32'(spill_req_o), 32'd0);
    check("R8 fill", 32'(fill_req_o), 32'd0);
    check("R8 rdata", rd_a_data_o, 32'd0);

    // table walk: R1 R2 R3 R5 R7
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [4:0]  ad;
      logic [31:0] dv;
      logic [2:0]  ec;
      logic        es, ef;
      {op, ad, dv, ec, es, ef} = VEC[i];
      case (op)
        OP_WR: begin wr_en_i = 1; wr_addr_i = ad; wr_data_i = dv; end
        OP_RD: begin rd_a_addr_i = ad; rd_b_addr_i = ad; end
        OP_SV: save_i = 1;
        default: restore_i = 1;
      endcase
      tick();
      if (op == OP_RD) begin
        check("R1/R2/R7 port A", rd_a_data_o, dv);
        check("R1/R2/R7 port B", rd_b_data_o, dv);
      end
      check("R3 cwp", 32'(cwp_o), 32'(ec));
      check("R4 spill", 32'(spill_req_o), 32'(es));
      check("R5 fill", 32'(fill_req_o), 32'(ef));
    end

    // R6 write-first bypass on a same-cycle read
    wr_en_i = 1; wr_addr_i = 5'd17; wr_data_i = 32'hABCD_0017;
    rd_a_addr_i = 5'd17; rd_b_addr_i = 5'd1;
    tick();
    check("R6 bypass A", rd_a_data_o, 32'hABCD_0017);
    check("R6 other B", rd_b_data_o, 32'h0000_0033);

    // R4: six saves reach window 2, the seventh hits invalid window 1
    do_save(3'd7, 1'b0, "R3 save");
    do_save(3'd6, 1'b0, "R3 save");
    do_save(3'd5, 1'b0, "R3 save");
    do_save(3'd4, 1'b0, "R3 save");
    do_save(3'd3, 1'b0, "R3 save");
    do_save(3'd2, 1'b0, "R3 save");
    do_save(3'd2, 1'b1, "R4 overflow");
    tick();
    check("R4 pulse ends", 32'(spill_req_o), 32'd0);

    // R9 mask load with a save in the same cycle: judged on old mask
    wim_we_i = 1; wim_d_i = 8'h00; save_i = 1;
    tick();
    check("R9 old mask used", 32'(spill_req_o), 32'd1);
    check("R9 mask loaded", 32'(wim_o), 32'h00);
    do_save(3'd1, 1'b0, "R9 new mask");

    // R3 wrap upward 1..7 -> 0, then downward 0 -> 7
    for (int k = 2; k <= 8; k++) do_restore(3'(k), 1'b0, "R3 restore wrap");
    do_save(3'd7, 1'b0, "R3 save wrap");

    // R3 save wins over restore
    save_i = 1; restore_i = 1;
    tick();
    check("R3 both high", 32'(cwp_o), 32'd6);

    // R5 underflow with mask bit 7 set, pointer at 6
    wim_we_i = 1; wim_d_i = 8'h80;
    tick();
    do_restore(3'd6, 1'b1, "R5 underflow");
    check("R5 no spill", 32'(spill_req_o), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule